// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM

This block is a synthesizable model of a synchronous burst static RAM. Its read path is pipelined. The rising clock edge registers every synchronous input: the address, the write data, three chip enables, the two address strobes, the burst-advance input, the byte controls and the global write. An address strobe opens a burst at the presented address. The processor-side strobe (`adsp_n`) always opens the burst with a read. The controller-side strobe (`adsc_n`) opens it with a read or with a write, as the write inputs decide. After that, each cycle with no strobe either advances a 2-bit burst counter (`adv_n` low) or repeats the current word (`adv_n` high). In both cases that cycle reads or writes according to the write inputs sampled at the same edge.

The `mode` input selects the order of the four words. High gives interleaved order and low gives linear order. The bits above the lowest two stay fixed for the whole burst. Output enable and snooze act on the output without waiting for a clock edge. Instead of a tri-state data bus, the model has a data-valid flag. Because the read path is pipelined, a deselect cycle leaves the last read visible for one more cycle.

The controller has three states:
- `ST_IDLE`: no burst is open.
- `ST_BURST`: a burst is open and continuation cycles perform accesses.
- `ST_SLEEP`: snooze is active.

It has these transitions:
- Any state → `ST_SLEEP` when `zz` is high at the edge.
- Any state → `ST_BURST` on a strobe while selected.
- Any state → `ST_IDLE` on a strobe while not selected.
- `ST_BURST` → `ST_BURST` on a continuation cycle.
- `ST_SLEEP` → `ST_IDLE` when `zz` is low and no strobe is present.

Top module: `burst_sram`

## Requirements
- R1: While reset is asserted, and at the first edge after its release, `dout_vld` is 0.
- R2: An edge with a strobe low, but with `ce_n` high, `ce2` low or `ce2_n` high, is a deselect cycle. It performs no access, so a write requested in that cycle leaves memory unchanged, and it closes any open burst.
- R3: A write is requested when `gw_n` is low, which writes all four bytes. It is also requested when `bwe_n` is low and at least one `bw_n` bit is low; then byte b (data bits 8b+7..8b) is written only where `bw_n[b]` is 0. With `gw_n` and `bwe_n` both high, the cycle is a read.
- R4: The cycle in which `adsp_n` starts a burst is always a read. The write inputs are ignored in that cycle.
- R5: Read data for an access registered at edge k is on `dout`, with `dout_vld` high, after edge k+1. Writes never raise `dout_vld`.
- R6: With `mode` high, access n of a burst (n = 0..3) uses low address bits start XOR n.
- R7: With `mode` low, access n of a burst uses low address bits (start + n) mod 4. The bits above bit 1 stay unchanged.
- R8: A continuation cycle with `adv_n` high repeats the address of the previous access.
- R9: While `oe_n` is high, `dout_vld` is 0 at once. The registered read data is kept and reappears when `oe_n` returns low.
- R10: While `zz` is high, `dout_vld` is 0 at once. An edge with `zz` high performs no access and ends the burst, so a later cycle with no strobe performs no access.
- R11: After a deselect cycle that follows a read, the read stays visible for one more cycle. `dout_vld` falls one cycle later.
- R12: Continuation cycles after an `adsp_n` start write when the write inputs request it, using the byte enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Word address |
| din | input | 8*NBYTES | Write data |
| ce_n | input | 1 | Chip enable, active low |
| ce2 | input | 1 | Chip enable, active high |
| ce2_n | input | 1 | Second chip enable, active low |
| adsp_n | input | 1 | Processor-side address strobe, active low |
| adsc_n | input | 1 | Controller-side address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| bw_n | input | NBYTES | Per-byte write enables, active low |
| bwe_n | input | 1 | Byte-write enable, active low |
| gw_n | input | 1 | Global write, active low |
| mode | input | 1 | 1 = interleaved order, 0 = linear order |
| oe_n | input | 1 | Output enable, asynchronous, active low |
| zz | input | 1 | Snooze, active high |
| dout | output | 8*NBYTES | Read data, 0 when not valid |
| dout_vld | output | 1 | Read data valid |

## Verification
Each access is registered at one edge and completes at the next. A read is therefore due on `dout` after the second edge following the cycle that drove it. A write is in memory in time for any access registered one edge later. The bench drives inputs at the falling edge and checks outputs at the falling edge. It keeps a one-entry queue of the expected result, so every check compares the access issued one call earlier. That expectation is masked by the bench's own `oe_n` and `zz` levels, which act without a clock. The `oe_n` and `zz` checks are also made one time step after toggling, between edges.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_BURST = 2'd1,
        ST_SLEEP = 2'd2
    } bst_state_e;

    // low two address bits for burst position cnt from start bits
    function automatic logic [1:0] seq_lo(input logic [1:0] start,
                                          input logic [1:0] cnt,
                                          input logic       interleave);
        return interleave ? (start ^ cnt) : 2'(start + cnt);
    endfunction

endpackage

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import burst_sram_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          step,
    input  logic          interleave,
    input  logic [AW-1:0] addr_in,
    output logic [AW-1:0] cur_addr
);

    logic [AW-1:0] base_q;
    logic [1:0]    cnt_q;
    logic [1:0]    cnt_use;

    always_comb begin
        cnt_use  = step ? 2'(cnt_q + 2'd1) : cnt_q;
        cur_addr = load ? addr_in
                        : {base_q[AW-1:2], seq_lo(base_q[1:0], cnt_use, interleave)};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            cnt_q  <= '0;
        end else if (load) begin
            base_q <= addr_in;
            cnt_q  <= '0;
        end else if (step) begin
            cnt_q  <= cnt_use;
        end
    end

endmodule

// File: rtl/burst_ctrl.sv
module burst_ctrl
    import burst_sram_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       zz,
    input  logic       sel,
    input  logic       adsp_n,
    input  logic       adsc_n,
    input  logic       adv_n,
    input  logic       wr_req,
    output logic       load,
    output logic       step,
    output logic       acc_en,
    output logic       acc_wr,
    output bst_state_e state
);

    bst_state_e nxt;
    logic       strobe;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt    = state;
        load   = 1'b0;
        step   = 1'b0;
        acc_en = 1'b0;
        acc_wr = 1'b0;
        strobe = !adsp_n || !adsc_n;
        if (zz) begin
            nxt = ST_SLEEP;
        end else if (strobe) begin
            if (sel) begin
                nxt    = ST_BURST;
                load   = 1'b1;
                acc_en = 1'b1;
                acc_wr = adsp_n && wr_req;
            end else begin
                nxt = ST_IDLE;
            end
        end else begin
            unique case (state)
                ST_BURST: begin
                    acc_en = 1'b1;
                    step   = !adv_n;
                    acc_wr = wr_req;
                end
                ST_SLEEP: nxt = ST_IDLE;
                default:  nxt = ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/sram_bank.sv
module sram_bank #(
    parameter int AW = 6,
    parameter int NB = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic            we,
    input  logic [NB-1:0]   be,
    input  logic [AW-1:0]   addr,
    input  logic [NB*8-1:0] wdata,
    output logic [NB*8-1:0] rdata,
    output logic            rvalid
);

    localparam int DEPTH = 1 << AW;

    for (genvar b = 0; b < NB; b++) begin : g_lane
        logic [7:0] lane [DEPTH];
        logic [7:0] lane_q;

        always_ff @(posedge clk) begin
            if (en && we && be[b]) lane[addr] <= wdata[b*8 +: 8];
            if (en && !we)         lane_q     <= lane[addr];
        end

        assign rdata[b*8 +: 8] = lane_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rvalid <= 1'b0;
        else        rvalid <= en && !we;
    end

endmodule

// File: rtl/burst_sram.sv
module burst_sram
    import burst_sram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int NBYTES = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [NBYTES*8-1:0] din,
    input  logic                ce_n,
    input  logic                ce2,
    input  logic                ce2_n,
    input  logic                adsp_n,
    input  logic                adsc_n,
    input  logic                adv_n,
    input  logic [NBYTES-1:0]   bw_n,
    input  logic                bwe_n,
    input  logic                gw_n,
    input  logic                mode,
    input  logic                oe_n,
    input  logic                zz,
    output logic [NBYTES*8-1:0] dout,
    output logic                dout_vld
);

    localparam int DW = NBYTES * 8;

    logic              sel;
    logic              wr_req;
    logic [NBYTES-1:0] be_now;
    logic              load, step, acc_en, acc_wr_c;
    bst_state_e        state;
    logic [ADDR_W-1:0] cur_addr;

    logic              acc_rd, acc_wr;
    logic [ADDR_W-1:0] acc_addr;
    logic [NBYTES-1:0] acc_be;
    logic [DW-1:0]     acc_din;
    logic [DW-1:0]     rdata;
    logic              out_vld;

    always_comb begin
        sel    = !ce_n && ce2 && !ce2_n;
        wr_req = !gw_n || (!bwe_n && (|(~bw_n)));
        be_now = !gw_n ? '1 : ~bw_n;
    end

    burst_ctrl u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .zz     (zz),
        .sel    (sel),
        .adsp_n (adsp_n),
        .adsc_n (adsc_n),
        .adv_n  (adv_n),
        .wr_req (wr_req),
        .load   (load),
        .step   (step),
        .acc_en (acc_en),
        .acc_wr (acc_wr_c),
        .state  (state)
    );

    burst_addr_gen #(.AW(ADDR_W)) u_agen (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .step       (step),
        .interleave (mode),
        .addr_in    (addr),
        .cur_addr   (cur_addr)
    );

    // address / write register stage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_rd   <= 1'b0;
            acc_wr   <= 1'b0;
            acc_addr <= '0;
            acc_be   <= '0;
            acc_din  <= '0;
        end else begin
            acc_rd <= acc_en && !acc_wr_c;
            acc_wr <= acc_en && acc_wr_c;
            if (acc_en) begin
                acc_addr <= cur_addr;
                acc_be   <= be_now;
                acc_din  <= din;
            end
        end
    end

    sram_bank #(.AW(ADDR_W), .NB(NBYTES)) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (acc_rd || acc_wr),
        .we     (acc_wr),
        .be     (acc_be),
        .addr   (acc_addr),
        .wdata  (acc_din),
        .rdata  (rdata),
        .rvalid (out_vld)
    );

    always_comb begin
        dout_vld = out_vld && !oe_n && !zz;
        dout     = dout_vld ? rdata : '0;
    end

endmodule

// File: rtl/burst_sram_chk.sv
module burst_sram_chk
    import burst_sram_pkg::*;
#(
    parameter int AW = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic          zz,
    input logic          adsp_n,
    input logic          adsc_n,
    input logic          adv_n,
    input logic          mode,
    input logic          sel,
    input bst_state_e    state,
    input logic          acc_rd,
    input logic          acc_wr,
    input logic [AW-1:0] acc_addr,
    input logic          out_vld
);

    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!out_vld && !acc_rd && !acc_wr));

    assert_desel_noacc_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!zz && (!adsp_n || !adsc_n) && !sel) |=> (!acc_rd && !acc_wr));

    assert_adsp_reads_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!zz && !adsp_n && sel) |=> (acc_rd && !acc_wr));

    assert_read_pipe_R5: assert property (@(posedge clk) disable iff (!rst_n)
        acc_rd |=> out_vld);

    assert_write_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_rd |=> !out_vld);

    assert_group_fixed_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BURST && !zz && adsp_n && adsc_n)
        |=> acc_addr[AW-1:2] == $past(acc_addr[AW-1:2]));

    assert_linear_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BURST && !zz && adsp_n && adsc_n && !adv_n && !mode && !$past(mode))
        |=> acc_addr[1:0] == 2'($past(acc_addr[1:0]) + 2'd1));

    assert_suspend_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BURST && !zz && adsp_n && adsc_n && adv_n)
        |=> $stable(acc_addr));

    assert_snooze_noacc_R10: assert property (@(posedge clk) disable iff (!rst_n)
        zz |=> (!acc_rd && !acc_wr && state == ST_SLEEP));

endmodule

bind burst_sram burst_sram_chk #(.AW(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .zz       (zz),
    .adsp_n   (adsp_n),
    .adsc_n   (adsc_n),
    .adv_n    (adv_n),
    .mode     (mode),
    .sel      (sel),
    .state    (state),
    .acc_rd   (acc_rd),
    .acc_wr   (acc_wr),
    .acc_addr (acc_addr),
    .out_vld  (out_vld)
);

// File: tb/burst_sram_test.sv
module burst_sram_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  addr;
    logic [31:0] din;
    logic        ce_n, ce2, ce2_n, adsp_n, adsc_n, adv_n;
    logic [3:0]  bw_n;
    logic        bwe_n, gw_n, mode, oe_n, zz;
    logic [31:0] dout;
    logic        dout_vld;

    int errors = 0;
    int checks = 0;
    bit done   = 0;

    logic [31:0] model_mem [64];
    logic        p_v = 1'b0;
    logic [31:0] p_d = '0;
    string       p_tag = "R1";

    // {mode, pos0, pos1, pos2, pos3}
    localparam logic [8:0] VEC [8] = '{
        9'b1_00_01_10_11, 9'b1_01_00_11_10, 9'b1_10_11_00_01, 9'b1_11_10_01_00,
        9'b0_00_01_10_11, 9'b0_01_10_11_00, 9'b0_10_11_00_01, 9'b0_11_00_01_10
    };

    burst_sram uut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .din(din), .ce_n(ce_n), .ce2(ce2),
        .ce2_n(ce2_n), .adsp_n(adsp_n), .adsc_n(adsc_n), .adv_n(adv_n), .bw_n(bw_n),
        .bwe_n(bwe_n), .gw_n(gw_n), .mode(mode), .oe_n(oe_n), .zz(zz),
        .dout(dout), .dout_vld(dout_vld)
    );

    always #10 clk = ~clk;

    function automatic logic [31:0] pat(input int a);
        logic [7:0] b = 8'(a);
        return {8'(b + 8'h30), b ^ 8'hC3, ~b, b};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic dflt();
        ce_n = 0; ce2 = 1; ce2_n = 0; adsp_n = 1; adsc_n = 1; adv_n = 1;
        bw_n = 4'hF; bwe_n = 1; gw_n = 1; din = 32'h0; addr = 6'h0;
    endtask

    // one clock; checks the access issued by the previous call
    task automatic step(input logic v, input logic [31:0] d, input string tag);
        logic vis;
        @(posedge clk);
        @(negedge clk);
        vis = p_v && !oe_n && !zz;
        chk(dout_vld == vis, p_tag, 32'(dout_vld), 32'(vis));
        if (vis) chk(dout == p_d, p_tag, dout, p_d);
        p_v = v; p_d = d; p_tag = tag;
    endtask

    task automatic wr_gw(input int a, input logic [31:0] d, input string tag);
        adsc_n = 0; gw_n = 0; addr = 6'(a); din = d;
        step(0, 0, tag);
        model_mem[a] = d;
        dflt();
    endtask

    task automatic rd_adsp(input int a, input string tag);
        adsp_n = 0; gw_n = 0; bwe_n = 0; bw_n = 4'h0; din = 32'hDEAD_BEEF; addr = 6'(a);
        step(1, model_mem[a], tag);
        dflt();
    endtask

    task automatic adv_rd(input int a, input string tag);
        adv_n = 0; addr = 6'h3F;
        step(1, model_mem[a], tag);
        dflt();
    endtask

    task automatic desel(input string tag);
        adsc_n = 0; ce_n = 1;
        step(0, 0, tag);
        dflt();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        dflt(); mode = 1; oe_n = 0; zz = 0;
        repeat (3) @(negedge clk);
        chk(dout_vld == 0, "R1", 32'(dout_vld), 0);
        rst_n = 1;
        step(0, 0, "R1");

        // preload every word with a full-word write (R3)
        for (int a = 0; a < 64; a++) wr_gw(a, pat(a), "R3");
        desel("R2");

        // burst orderings (R6 interleaved, R7 linear)
        for (int i = 0; i < 8; i++) begin
            logic [8:0] v = VEC[i];
            string tg = v[8] ? "R6" : "R7";
            int grp = (i + 1) * 4;
            mode = v[8];
            rd_adsp(grp + int'(v[7:6]), tg);
            adv_rd(grp + int'(v[5:4]), tg);
            adv_rd(grp + int'(v[3:2]), tg);
            adv_rd(grp + int'(v[1:0]), tg);
            desel(tg);
        end
        mode = 1;

        // suspend repeats address (R8)
        rd_adsp(52, "R8");
        adv_rd(53, "R8");
        step(1, model_mem[53], "R8");
        adv_rd(54, "R8");
        desel("R8");

        // byte write: bytes 0 and 2 (R3)
        adsc_n = 0; bwe_n = 0; bw_n = 4'b1010; din = 32'h1122_3344; addr = 6'd33;
        step(0, 0, "R3");
        model_mem[33] = {model_mem[33][31:24], 8'h22, model_mem[33][15:8], 8'h44};
        dflt();
        desel("R3");
        rd_adsp(33, "R3");
        // no write enable active -> read
        adsc_n = 0; bw_n = 4'h0; din = 32'hFFFF_FFFF; addr = 6'd34;
        step(1, model_mem[34], "R3");
        dflt();
        desel("R3");

        // ADSP start ignores writes, continuation writes (R4, R12)
        rd_adsp(40, "R4");
        adv_n = 0; bwe_n = 0; bw_n = 4'b0000; din = 32'hA5A5_0F0F;
        step(0, 0, "R12");
        model_mem[41] = 32'hA5A5_0F0F;
        dflt();
        desel("R12");
        rd_adsp(40, "R4");
        desel("R12");
        rd_adsp(41, "R12");
        desel("R12");

        // each disabled enable blocks a write (R2)
        for (int k = 0; k < 3; k++) begin
            adsc_n = 0; gw_n = 0; addr = 6'd50; din = ~model_mem[50];
            if (k == 0) ce_n = 1;
            if (k == 1) ce2 = 0;
            if (k == 2) ce2_n = 1;
            step(0, 0, "R2");
            dflt();
        end
        rd_adsp(50, "R2");

        // double-cycle deselect (R11)
        desel("R11");
        desel("R11");
        desel("R11");

        // asynchronous output enable (R9)
        rd_adsp(44, "R9");
        desel("R9");
        oe_n = 1; #1;
        chk(dout_vld == 0, "R9", 32'(dout_vld), 0);
        oe_n = 0; #1;
        chk(dout_vld == 1 && dout == model_mem[44], "R9", dout, model_mem[44]);
        desel("R9");

        // snooze (R10)
        rd_adsp(45, "R10");
        zz = 1; adv_n = 0;
        step(0, 0, "R10");
        zz = 0;
        step(0, 0, "R10");
        step(0, 0, "R10");
        dflt();
        desel("R10");
        rd_adsp(46, "R10");
        zz = 1; #1;
        chk(dout_vld == 0, "R10", 32'(dout_vld), 0);
        zz = 0;
        desel("R10");
        desel("R10");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule